// File: doc/BRIEF.md
# Power-Gated Register Bank with Retention Shadow and Output Clamp

This block models the boundary of a power domain that can be switched off. Inside the domain sits a small bank of registers. Each register has a shadow copy that lives on an always-on supply. Every domain output passes through a clamp. The bench or the surrounding power controller drives four controls: the always-on reset, a power-good flag for the switched supply, an active-low retention control `ret_n`, and an isolation enable.

In the intended sequence, software first writes the bank while `ret_n` is low. It then raises `iso_en` and raises `ret_n`, which saves the bank into the shadow copy. Next it drops power-good. While power is off, the bank holds a known scramble pattern and is flagged invalid. After power-good returns, lowering `ret_n` restores the saved values and clears the invalid flag. Finally, isolation is released.

A restore attempted while the domain is still off does not happen. Instead it sets a sticky error flag that only reset clears.

Top module: `pwr_domain_shell`

## Requirements
- R1: While `iso_en` is 1, every bit of `dout` equals the parameter `CLAMP` (default 1). While `iso_en` is 0, `dout` carries register i in bits [i*W +: W].
- R2: While `rst_n` is low, all registers and the shadow copy are zero, and `regs_invalid` and `restore_err` are 0. This holds even if they were set before the reset.
- R3: With power-good high, `ret_n` low and `wr_en` high, register `wr_addr` takes `wr_data` at the clock edge.
- R4: At the first clock edge that samples `ret_n` high after it was low, if power-good is high, the shadow copy captures the register values held before that edge.
- R5: While `ret_n` is high, `wr_en` has no effect on the registers.
- R6: At every clock edge that samples power-good low, register i is loaded with `SCRAMBLE ^ i` and `regs_invalid` becomes 1.
- R7: At the first clock edge that samples `ret_n` low after it was high, if power-good is high, the registers take the shadow values and `regs_invalid` becomes 0.
- R8: A falling `ret_n` sampled while power-good is low restores nothing and sets `restore_err`. `restore_err` then stays 1 until reset, including across a later successful restore.
- R9: A rising `ret_n` sampled while power-good is low leaves the shadow copy unchanged. The earlier saved values are still the ones a later restore returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, always-on |
| pwr_good | input | 1 | Switched supply is up |
| ret_n | input | 1 | Retention control: rising edge saves, falling edge restores |
| iso_en | input | 1 | Clamp all domain outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NREG) | Register select |
| wr_data | input | W | Write data |
| dout | output | NREG*W | All registers, clamped while isolated |
| regs_invalid | output | 1 | Registers hold corrupted contents |
| restore_err | output | 1 | Sticky: restore requested while powered down |

## Verification
The hardest situations to reach are a `ret_n` edge that coincides with the supply being off. These appear only when the control sequence is out of order. The stimulus builds them on purpose. It raises `ret_n` in the very cycle that power-good falls, then restores after power returns, so the values that come back show whether the late save was dropped. In a separate sequence it lowers `ret_n` while power is still off, then checks that the error flag survives a later legal restore. During power-off, isolation is lifted for single cycles so the scramble pattern can be seen at the port.

// File: rtl/pwr_domain_shell.sv
module pwr_domain_shell #(
  parameter int NREG = 4,
  parameter int W = 8,
  parameter bit CLAMP = 1'b1,
  parameter logic [W-1:0] SCRAMBLE = 8'hA5,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic            ret_n,
  input  logic            iso_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  output logic [NREG*W-1:0] dout,
  output logic            regs_invalid,
  output logic            restore_err
);

  logic [W-1:0] main_q [NREG];
  logic [W-1:0] shadow_q [NREG];
  logic [NREG*W-1:0] main_flat, shadow_flat;
  logic ret_q, invalid_q, err_q;

  wire ret_rise = ret_n & ~ret_q;
  wire ret_fall = ~ret_n & ret_q;

  for (genvar g = 0; g < NREG; g++) begin : g_pack
    assign main_flat[g*W +: W]   = main_q[g];
    assign shadow_flat[g*W +: W] = shadow_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= 1'b0;
    end else begin
      ret_q <= ret_n;
    end
  end

  // Always-on shadow copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
    end else if (ret_rise && pwr_good) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= main_q[i];
    end
  end

  // Switched-domain registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) main_q[i] <= '0;
      invalid_q <= 1'b0;
      err_q <= 1'b0;
    end else if (!pwr_good) begin
      for (int i = 0; i < NREG; i++) main_q[i] <= SCRAMBLE ^ W'(i);
      invalid_q <= 1'b1;
      if (ret_fall) err_q <= 1'b1;
    end else if (ret_fall) begin
      for (int i = 0; i < NREG; i++) main_q[i] <= shadow_q[i];
      invalid_q <= 1'b0;
    end else if (!ret_n && wr_en) begin
      main_q[wr_addr] <= wr_data;
    end
  end

  assign dout = iso_en ? {(NREG*W){CLAMP}} : main_flat;
  assign regs_invalid = invalid_q;
  assign restore_err = err_q;

  p_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_rise && pwr_good) |=> shadow_flat == $past(main_flat));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_n && ret_q && pwr_good) |=> $stable(main_flat));

  p_corrupt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> regs_invalid);

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fall && pwr_good) |=> (main_flat == $past(shadow_flat)) && !regs_invalid);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fall && !pwr_good) |=> restore_err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_err |=> restore_err);

  p_no_save_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> $stable(shadow_flat));

endmodule

// File: tb/pwr_domain_shell_tb_top.sv
module pwr_domain_shell_tb_top;
  localparam int NREG = 4;
  localparam int W = 8;
  localparam bit CLAMP = 1'b1;
  localparam logic [W-1:0] SCR = 8'hA5;

  logic clk = 0, rst_n = 0, pwr_good = 0, ret_n = 0, iso_en = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [NREG*W-1:0] dout;
  logic regs_invalid, restore_err;

  always #10 clk = ~clk;

  pwr_domain_shell #(.NREG(NREG), .W(W), .CLAMP(CLAMP), .SCRAMBLE(SCR)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ret_n(ret_n), .iso_en(iso_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout),
    .regs_invalid(regs_invalid), .restore_err(restore_err));

  typedef struct {
    logic [NREG*W-1:0] dout;
    logic inv;
    logic err;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m [NREG];
  logic [W-1:0] s [NREG];
  logic m_inv = 0, m_err = 0, m_retq = 0;

  task automatic cyc(input logic r, pg, ret, iso, we, input logic [1:0] a,
                     input logic [W-1:0] d, input string tag);
    exp_t e;
    logic fall, rise;
    @(negedge clk);
    rst_n = r; pwr_good = pg; ret_n = ret; iso_en = iso;
    wr_en = we; wr_addr = a; wr_data = d;
    if (!r) begin
      for (int i = 0; i < NREG; i++) begin m[i] = '0; s[i] = '0; end
      m_inv = 0; m_err = 0; m_retq = 0;
    end else begin
      fall = m_retq && !ret;
      rise = ret && !m_retq;
      if (rise && pg) for (int i = 0; i < NREG; i++) s[i] = m[i];
      if (!pg) begin
        for (int i = 0; i < NREG; i++) m[i] = SCR ^ W'(i);
        m_inv = 1;
        if (fall) m_err = 1;
      end else if (fall) begin
        for (int i = 0; i < NREG; i++) m[i] = s[i];
        m_inv = 0;
      end else if (!ret && we) begin
        m[a] = d;
      end
      m_retq = ret;
    end
    for (int i = 0; i < NREG; i++) e.dout[i*W +: W] = m[i];
    if (iso) e.dout = {(NREG*W){CLAMP}};
    e.inv = m_inv; e.err = m_err; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (dout !== e.dout || regs_invalid !== e.inv || restore_err !== e.err) begin
          errors++;
          $display("FAIL %s: dout=%h exp=%h inv=%b exp=%b err=%b exp=%b",
                   e.tag, dout, e.dout, regs_invalid, e.inv, restore_err, e.err);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 reset state
    cyc(0, 1, 0, 0, 0, 0, 0, "R2 reset");
    cyc(0, 1, 0, 0, 0, 0, 0, "R2 reset");
    // R3 writes
    cyc(1, 1, 0, 0, 1, 0, 8'h11, "R3 write");
    cyc(1, 1, 0, 0, 1, 1, 8'h22, "R3 write");
    cyc(1, 1, 0, 0, 1, 2, 8'h33, "R3 write");
    cyc(1, 1, 0, 0, 1, 3, 8'h44, "R3 write");
    // R1 clamp and pass-through
    cyc(1, 1, 0, 1, 0, 0, 0, "R1 clamp");
    cyc(1, 1, 0, 0, 0, 0, 0, "R1 pass");
    // R4 save, R5 writes blocked while ret_n high
    cyc(1, 1, 1, 0, 0, 0, 0, "R4 save");
    cyc(1, 1, 1, 0, 1, 2, 8'hEE, "R5 blocked");
    cyc(1, 1, 1, 0, 1, 0, 8'hDD, "R5 blocked");
    // R6 power off, isolated, then peek
    cyc(1, 1, 1, 1, 0, 0, 0, "R1 iso on");
    cyc(1, 0, 1, 1, 0, 0, 0, "R6 off iso");
    cyc(1, 0, 1, 0, 1, 1, 8'h77, "R6 scramble");
    cyc(1, 0, 1, 1, 0, 0, 0, "R6 off iso");
    cyc(1, 1, 1, 1, 0, 0, 0, "R6 still invalid");
    // R7 restore
    cyc(1, 1, 0, 1, 0, 0, 0, "R7 restore");
    cyc(1, 1, 0, 0, 0, 0, 0, "R7 restored");
    // R9 save while off is dropped
    cyc(1, 1, 0, 0, 1, 1, 8'h99, "R3 write");
    cyc(1, 0, 1, 0, 0, 0, 0, "R9 save off");
    cyc(1, 0, 1, 0, 0, 0, 0, "R6 scramble");
    cyc(1, 1, 1, 0, 0, 0, 0, "R9 power back");
    cyc(1, 1, 0, 0, 0, 0, 0, "R9 old copy");
    cyc(1, 1, 0, 0, 0, 0, 0, "R9 old copy");
    // R8 restore while off
    cyc(1, 1, 0, 0, 1, 3, 8'h5C, "R3 write");
    cyc(1, 1, 1, 0, 0, 0, 0, "R4 save");
    cyc(1, 0, 1, 0, 0, 0, 0, "R6 scramble");
    cyc(1, 0, 0, 0, 0, 0, 0, "R8 bad restore");
    cyc(1, 1, 0, 0, 0, 0, 0, "R8 sticky");
    cyc(1, 1, 0, 0, 0, 0, 0, "R8 still scrambled");
    cyc(1, 1, 1, 0, 0, 0, 0, "R4 save scrambled");
    cyc(1, 1, 0, 0, 0, 0, 0, "R8 err survives restore");
    cyc(1, 1, 0, 1, 0, 0, 0, "R1 clamp");
    // R2 reset clears flags
    cyc(0, 1, 0, 0, 0, 0, 0, "R2 reset clears");
    cyc(1, 1, 0, 0, 0, 0, 0, "R2 after reset");
    @(posedge clk); #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule